// File: doc/BRIEF.md
# Serial Flash Status Register Write Controller

This block holds the 8-bit status register of a serial NOR flash device together with the logic that reads and writes it. A host reaches it through a mode-0 SPI slave port: active-low chip select, serial clock, serial data in and serial data out. The serial pins are brought into the system clock domain through synchronizers, so the serial clock must run several times slower than the system clock. Three instructions are decoded: write-enable, read-status and write-status. A write-status that passes every guard starts a self-timed write cycle lasting a fixed number of system clocks. During that cycle the busy flag reads 1, and at its end the new protection bits are committed.

Protection comes from three sources. A write-enable latch must be armed beforehand. A protect bit combined with a low write-protect pin locks the register. In one-time-programmable mode the instruction ignores its data byte and sets a permanent lock bit instead. The block-protect field and the lock bit are driven out for a downstream array-protection checker. The mode input is a static strap that the host changes only while the device is idle.

Top module: `sfsr_ctrl`

## Requirements
- R1: Opcode 0x05 followed by clocks shifts the status byte out MSB first, with each bit changing after a falling serial clock edge and starting after the eighth opcode bit. The byte repeats for as long as chip select stays low. The layout is: bit 7 is the protect bit (or the lock bit in OTP mode), bits 6:5 are zero, bits 4:2 are block-protect, bit 1 is the write-enable latch (WEL) and bit 0 is busy (WIP).
- R2: Opcode 0x06 sets WEL only when chip select rises after exactly 8 bits.
- R3: Write-status (opcode 0x01) has no effect unless WEL is 1.
- R4: Write-status is discarded unless chip select rises after exactly 16 bits (opcode plus one data byte). Shorter and longer frames are both discarded and leave WEL unchanged.
- R5: An accepted write-status holds WIP at 1 for exactly TW_CYCLES system clocks. Reads during that window return the old bits 7 and 4:2 with WEL=1. At the end the new bits are committed and WEL is cleared.
- R6: Data bits 6, 5, 1 and 0 of a write-status have no effect, and bits 6:5 always read 0.
- R7: When the protect bit is 1 and wp_n is low (outside OTP mode), write-status is rejected: no busy cycle starts, no bit changes and WEL stays set.
- R8: While WIP is 1, write-enable and write-status are ignored and read-status still works.
- R9: In OTP mode an accepted write-status ignores its data, leaves block-protect and the protect bit unchanged, and sets the lock bit. The lock bit is never cleared afterwards, and status bit 7 shows it only while in OTP mode.
- R10: After reset the status reads 0x00, and bp_o and otp_lock_o are 0.
- R11: bp_o always equals status bits 4:2 and otp_lock_o equals the lock bit. Both change only when a write cycle completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host, 0 when not reading |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | OTP mode strap |
| bp_o | output | 3 | Committed block-protect field |
| otp_lock_o | output | 1 | One-time lock bit |

## Verification
The assertions check on every cycle that a write cycle starts only with WEL armed, outside hardware protection and while idle. They also check that the busy window lasts exactly TW_CYCLES clocks, that WEL is clear once busy falls, that the protection bits move only at completion, and that the lock never drops. Only the bench scenarios can show the serial side: frame length filtering, the bit order and repetition of the read-out, the old values visible mid-cycle, and the mode-dependent meaning of bit 7. The bench also sweeps the relevant data bit combinations to show which bits are written and which are ignored.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam logic [7:0] OPC_WR_EN   = 8'h06;
  localparam logic [7:0] OPC_RD_STAT = 8'h05;
  localparam logic [7:0] OPC_WR_STAT = 8'h01;
  localparam int CMD_BITS  = 8;
  localparam int WR_BITS   = 16;
  localparam int CNT_W     = 5;
  localparam int PIN_LINES = 4;

  // synchronizer lane order {wp_n, sdi, sclk, cs_n}; idle values on reset
  localparam logic [PIN_LINES-1:0] PIN_IDLE = 4'b1001;

  typedef struct packed {
    logic       prot;
    logic [2:0] bp;
  } sfsr_nv_t;
endpackage

// File: rtl/sfsr_spi_front.sv
module sfsr_spi_front
  import sfsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             wp_n,
  input  logic [7:0]       status_i,
  output logic             frame_end,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opcode,
  output logic [7:0]       last_byte,
  output logic             sdo,
  output logic             wp_n_s
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PIN_LINES-1:0] stg [SYNC_STAGES];
  logic [PIN_LINES-1:0] pins_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= PIN_IDLE;
          else        stg[g] <= {wp_n, sdi, sclk, cs_n};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= PIN_IDLE;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign pins_s = stg[SYNC_STAGES-1];

  logic cs_s, sclk_s, sdi_s;
  assign cs_s   = pins_s[0];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[2];
  assign wp_n_s = pins_s[3];

  logic cs_d, sclk_d;
  logic rise, fall;
  assign rise      = sclk_s & ~sclk_d & ~cs_s;
  assign fall      = ~sclk_s & sclk_d & ~cs_s;
  assign frame_end = cs_s & ~cs_d;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       sr_q, sr_n, opc_q, opc_n, snap_q, snap_n;
  logic [2:0]       idx_q, idx_n;
  logic             sdo_q, sdo_n;

  always_comb begin
    cnt_n  = cnt_q;
    sr_n   = sr_q;
    opc_n  = opc_q;
    snap_n = snap_q;
    idx_n  = idx_q;
    sdo_n  = sdo_q;
    if (cs_s) begin
      cnt_n = '0;
      idx_n = '0;
      sdo_n = 1'b0;
    end else begin
      if (rise) begin
        sr_n = {sr_q[6:0], sdi_s};
        if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(CMD_BITS - 1)) opc_n = {sr_q[6:0], sdi_s};
      end
      if (fall && (cnt_q >= CNT_W'(CMD_BITS)) && (opc_q == OPC_RD_STAT)) begin
        if (idx_q == 3'd0) begin
          snap_n = status_i;
          sdo_n  = status_i[7];
        end else begin
          sdo_n  = snap_q[3'd7 - idx_q];
        end
        idx_n = idx_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
      opc_q  <= '0;
      snap_q <= '0;
      idx_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      cnt_q  <= cnt_n;
      sr_q   <= sr_n;
      opc_q  <= opc_n;
      snap_q <= snap_n;
      idx_q  <= idx_n;
      sdo_q  <= sdo_n;
    end
  end

  assign bit_cnt   = cnt_q;
  assign opcode    = opc_q;
  assign last_byte = sr_q;
  assign sdo       = sdo_q;
endmodule

// File: rtl/sfsr_decode.sv
module sfsr_decode
  import sfsr_pkg::*;
(
  input  logic             frame_end,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic [7:0]       opcode,
  input  logic             busy,
  input  logic             wel,
  input  logic             hpm,
  output logic             set_wel,
  output logic             start_wr
);
  logic len_cmd, len_wr, idle_end;

  always_comb begin
    idle_end = frame_end & ~busy;
    len_cmd  = (bit_cnt == CNT_W'(CMD_BITS));
    len_wr   = (bit_cnt == CNT_W'(WR_BITS));
    set_wel  = idle_end & len_cmd & (opcode == OPC_WR_EN);
    start_wr = idle_end & len_wr & (opcode == OPC_WR_STAT) & wel & ~hpm;
  end
endmodule

// File: rtl/sfsr_wtimer.sv
module sfsr_wtimer #(
  parameter int TW_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int TW_W = (TW_CYCLES < 2) ? 1 : $clog2(TW_CYCLES);

  logic [TW_W-1:0] cnt_q, cnt_n;
  logic            busy_q, busy_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (start && !busy_q) begin
      busy_n = 1'b1;
      cnt_n  = TW_W'(TW_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;
  assign done = busy_q & (cnt_q == '0);
endmodule

// File: rtl/sfsr_ctrl.sv
module sfsr_ctrl
  import sfsr_pkg::*;
#(
  parameter int TW_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  input  logic       wp_n,
  input  logic       otp_mode,
  output logic [2:0] bp_o,
  output logic       otp_lock_o
);
  logic             frame_end, wp_n_s;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       opcode, last_byte, status;
  logic             set_wel, start_wr, busy, done, hpm;

  sfsr_nv_t nv_q, nv_n, pend_q, pend_n;
  logic     lock_q, lock_n, wel_q, wel_n, pend_otp_q, pend_otp_n;
  logic     srp_q;

  assign srp_q  = nv_q.prot;
  assign status = {(otp_mode ? lock_q : nv_q.prot), 2'b00, nv_q.bp, wel_q, busy};
  assign hpm    = nv_q.prot & ~wp_n_s & ~otp_mode;

  sfsr_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .wp_n(wp_n),
    .status_i(status), .frame_end(frame_end), .bit_cnt(bit_cnt),
    .opcode(opcode), .last_byte(last_byte), .sdo(sdo), .wp_n_s(wp_n_s)
  );

  sfsr_decode u_dec (
    .frame_end(frame_end), .bit_cnt(bit_cnt), .opcode(opcode), .busy(busy),
    .wel(wel_q), .hpm(hpm), .set_wel(set_wel), .start_wr(start_wr)
  );

  sfsr_wtimer #(.TW_CYCLES(TW_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_wr), .busy(busy), .done(done)
  );

  always_comb begin
    nv_n       = nv_q;
    lock_n     = lock_q;
    wel_n      = wel_q;
    pend_n     = pend_q;
    pend_otp_n = pend_otp_q;
    if (done)         wel_n = 1'b0;
    else if (set_wel) wel_n = 1'b1;
    if (start_wr) begin
      pend_n.prot = last_byte[7];
      pend_n.bp   = last_byte[4:2];
      pend_otp_n  = otp_mode;
    end
    if (done) begin
      if (pend_otp_q) lock_n = 1'b1;
      else            nv_n   = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q       <= '0;
      lock_q     <= 1'b0;
      wel_q      <= 1'b0;
      pend_q     <= '0;
      pend_otp_q <= 1'b0;
    end else begin
      nv_q       <= nv_n;
      lock_q     <= lock_n;
      wel_q      <= wel_n;
      pend_q     <= pend_n;
      pend_otp_q <= pend_otp_n;
    end
  end

  assign bp_o       = nv_q.bp;
  assign otp_lock_o = lock_q;
endmodule

// File: rtl/sfsr_ctrl_chk.sv
module sfsr_ctrl_chk #(
  parameter int TW_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       start_wr,
  input logic       set_wel,
  input logic       wel,
  input logic       hpm,
  input logic       lock,
  input logic       srp,
  input logic [2:0] bp
);
  localparam int LW = $clog2(TW_CYCLES + 2) + 1;
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 1'b1;
    else           len_q <= '0;
  end

  assert_wel_needed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> wel);
  assert_hpm_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> !hpm);
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!start_wr && !set_wel));
  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == LW'(TW_CYCLES)));
  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q < LW'(TW_CYCLES)));
  assert_wel_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  assert_commit_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(bp) && $stable(srp)));
endmodule

bind sfsr_ctrl sfsr_ctrl_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .start_wr(start_wr),
  .set_wel(set_wel), .wel(wel_q), .hpm(hpm), .lock(lock_q), .srp(srp_q), .bp(nv_q.bp)
);

// File: tb/sim_sfsr_ctrl.sv
`timescale 1ns/1ps
module sim_sfsr_ctrl;
  localparam int TW = 200;
  localparam int HALF = 5;

  logic clk, rst_n, cs_n, sclk, sdi, wp_n, otp_mode;
  logic sdo, otp_lock_o;
  logic [2:0] bp_o;
  int n_tests, n_fail;

  sfsr_ctrl #(.TW_CYCLES(TW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .wp_n(wp_n), .otp_mode(otp_mode), .bp_o(bp_o), .otp_lock_o(otp_lock_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = tx[n-1-i];
      tick(HALF);
      rx = {rx[30:0], sdo};
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(HALF);
  endtask

  task automatic wren();
    logic [31:0] rx;
    xfer(32'h06, 8, rx);
  endtask

  task automatic wrsr(input logic [7:0] d, input int nbits);
    logic [31:0] rx;
    logic [16:0] full;
    full = {8'h01, d, 1'b0};
    if (nbits == 17)      xfer({15'd0, full}, 17, rx);
    else if (nbits == 15) xfer({16'd0, full[16:2]}, 15, rx);
    else                  xfer({16'd0, full[16:1]}, 16, rx);
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [31:0] rx;
    xfer(32'h0500, 16, rx);
    v = rx[7:0];
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, d, e, oldv;
    logic [31:0] rx;
    n_tests = 0; n_fail = 0;
    cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; wp_n = 1'b1; otp_mode = 1'b0;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10 reset state
    rdsr(v); chk("R10 status", v, 8'h00);
    chk("R10 bp_o", {5'd0, bp_o}, 8'h00);
    chk("R10 lock", {7'd0, otp_lock_o}, 8'h00);

    // R3 write-status without WEL
    wrsr(8'h9C, 16); tick(TW + 50);
    rdsr(v); chk("R3 no wel", v, 8'h00);

    // R2 short write-enable frame, then proper one
    begin
      xfer(32'h03, 7, rx);
      rdsr(v); chk("R2 7-bit wren", v, 8'h00);
    end
    wren(); rdsr(v); chk("R2 wren", v, 8'h02);

    // R5 R6 R11 sweep of relevant data bit patterns
    oldv = 8'h00;
    for (int i = 0; i < 64; i++) begin
      logic [5:0] b;
      b = 6'(i);
      d = {b[5], b[0], b[1], b[4:2], b[1], b[0]};
      e = {d[7], 2'b00, d[4:2], 2'b00};
      wren();
      wrsr(d, 16);
      rdsr(v); chk("R5 busy read", v, {oldv[7], 2'b00, oldv[4:2], 2'b11});
      tick(TW + 50);
      rdsr(v); chk("R6 committed", v, e);
      chk("R11 bp_o", {5'd0, bp_o}, {5'd0, e[4:2]});
      oldv = e;
    end

    // R4 frame length filtering
    wren();
    wrsr(8'h9C, 15); tick(TW + 50);
    rdsr(v); chk("R4 15 bits", v, {oldv[7], 2'b00, oldv[4:2], 2'b10});
    wrsr(8'h9C, 17); tick(TW + 50);
    rdsr(v); chk("R4 17 bits", v, {oldv[7], 2'b00, oldv[4:2], 2'b10});
    wrsr(8'h9C, 16); tick(TW + 50);
    rdsr(v); chk("R4 16 bits", v, 8'h9C);

    // R1 repeated read-out
    xfer(32'h050000, 24, rx);
    chk("R1 first byte", rx[15:8], 8'h9C);
    chk("R1 repeat byte", rx[7:0], 8'h9C);

    // R8 write-status during busy ignored
    wren();
    wrsr(8'h10, 16);
    wrsr(8'h0C, 16);
    tick(TW + 50);
    rdsr(v); chk("R8 busy ignore", v, 8'h10);

    // R7 hardware protection
    wren(); wrsr(8'h8C, 16); tick(TW + 50);
    rdsr(v); chk("R7 set prot", v, 8'h8C);
    wp_n = 1'b0; tick(5);
    wren(); wrsr(8'h00, 16);
    rdsr(v); chk("R7 no busy", v, 8'h8E);
    tick(TW + 50);
    rdsr(v); chk("R7 rejected", v, 8'h8E);
    chk("R7 bp_o", {5'd0, bp_o}, 8'h03);
    wp_n = 1'b1; tick(5);
    wrsr(8'h00, 16); tick(TW + 50);
    rdsr(v); chk("R7 released", v, 8'h00);

    // R9 one-time lock
    wren(); wrsr(8'h1C, 16); tick(TW + 50);
    otp_mode = 1'b1; tick(5);
    rdsr(v); chk("R9 otp view", v, 8'h1C);
    wren(); wrsr(8'h00, 16); tick(TW + 50);
    rdsr(v); chk("R9 lock set", v, 8'h9C);
    chk("R9 lock pin", {7'd0, otp_lock_o}, 8'h01);
    chk("R9 bp kept", {5'd0, bp_o}, 8'h07);
    wren(); wrsr(8'h00, 16); tick(TW + 50);
    rdsr(v); chk("R9 relock", v, 8'h9C);
    otp_mode = 1'b0; tick(5);
    rdsr(v); chk("R9 normal view", v, 8'h1C);
    wren(); wrsr(8'h00, 16); tick(TW + 50);
    rdsr(v); chk("R9 normal write", v, 8'h00);
    chk("R9 lock stays", {7'd0, otp_lock_o}, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule